// File: doc/BRIEF.md
# SCSI Arbitration and Selection Sequencer

This block is the initiator-side engine that takes control of a parallel SCSI bus and then addresses one target on it. A one-cycle arbitration start makes it watch for the bus to go idle, wait for the bus to settle, drive BSY together with its own ID bit, and then decide whether it won. A one-cycle selection start makes it drive SEL with its own ID bit and the target's ID bit, optionally raise ATN, and give the target a programmable number of cycles to answer with BSY.

Each of the two operations ends with a one-cycle done pulse. Done comes with an arbitration-lost pulse when a higher ID or another device's SEL beat it, and with a selection-timeout pulse when the target never answered. A register block above this sequencer turns these pulses into status and interrupts. All waits are counted in clock cycles. The fixed waits are parameters, and the selection timeout is captured from an input when the selection start is accepted.

Top module: `scsi_arbsel_seq`

## Requirements
- R1: After reset, bsy_o, sel_o and atn_o are low, data_o is zero, and done_o, arb_lost_o and sel_tmo_o are low.
- R2: An arbitration start taken in idle checks the bus on the next edge. If bus_bsy_i and bus_sel_i are both low, bsy_o and bit OWN_ID of data_o rise BUS_FREE_CYC+SETTLE_CYC cycles later, and the decision follows ARB_CYC cycles after that. With the default delays, done_o is high 37 edges after the edge that took the start.
- R3: While the bus-free check sees bus_bsy_i or bus_sel_i high, the block repeats the check every BUS_FREE_CYC cycles and drives nothing.
- R4: If the bus is busy again when arbitration would begin, the block stays off the bus and checks for bus free again after CLEAR_CYC cycles.
- R5: Arbitration is won when no bus_data_i bit above bit OWN_ID is set and bus_sel_i is low. Lower IDs on the bus do not matter. On a win, sel_o rises while bsy_o and the own ID bit stay driven, and done_o pulses without arb_lost_o.
- R6: A bus_data_i bit above OWN_ID at the decision releases every driven line, and arb_lost_o pulses together with done_o.
- R7: bus_sel_i high at the decision is also a loss, with the same release and pulses as R6.
- R8: A selection start captures dest_id_i, atn_req_i and sel_tmo_i. One cycle later the block drives sel_o, the own ID bit plus bit dest_id_i of data_o, and atn_o equal to the captured request, and it releases bsy_o. The result is taken max(sel_tmo_i,1) cycles later. If bus_bsy_i is high then, sel_o and data_o drop, atn_o stays, and done_o pulses.
- R9: If bus_bsy_i is low at the end of the selection timeout, every line including atn_o is released, and sel_tmo_o pulses with done_o.
- R10: Starts are taken only in idle, and arbitration wins over selection when both arrive together. Starts that arrive while an operation runs change neither the outputs nor the timing of the result.
- R11: done_o, arb_lost_o and sel_tmo_o are single-cycle pulses, and arb_lost_o and sel_tmo_o never pulse together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arb_start_i | input | 1 | One-cycle request to arbitrate |
| sel_start_i | input | 1 | One-cycle request to select |
| atn_req_i | input | 1 | Raise ATN during the requested selection |
| dest_id_i | input | $clog2(BUS_W) | Target ID for selection |
| sel_tmo_i | input | TMO_W | Selection timeout in cycles |
| bus_bsy_i | input | 1 | BSY driven by other devices |
| bus_sel_i | input | 1 | SEL driven by other devices |
| bus_data_i | input | BUS_W | Data lines as seen on the bus, own drive included |
| bsy_o | output | 1 | BSY drive |
| sel_o | output | 1 | SEL drive |
| atn_o | output | 1 | ATN drive |
| data_o | output | BUS_W | ID bits driven onto the data lines |
| done_o | output | 1 | Operation finished |
| arb_lost_o | output | 1 | Arbitration was lost |
| sel_tmo_o | output | 1 | Selection timed out |

## Verification
A corrupted sequencer state or delay counter shows at the ports as a done pulse at the wrong edge. The bench compares every done pulse against an exact edge count, so an error of one cycle in any wait is reported at that operation's done pulse. A wrong win decision shows up in the same cycle as done, as the wrong levels on sel_o, bsy_o and data_o together with the lost flag. A start that is wrongly taken mid-operation either changes data_o within a few cycles or moves the done pulse, and both are checked.

// File: rtl/scsi_arbsel_pkg.sv
package scsi_arbsel_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BUS_FREE,
    ST_ARB_BEGIN,
    ST_ARB_END,
    ST_SEL_BEGIN,
    ST_SEL_END
  } seq_state_e;
endpackage

// File: rtl/arbsel_timer.sv
module arbsel_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/arbsel_judge.sv
module arbsel_judge #(
  parameter int BUS_W  = 8,
  parameter int OWN_ID = 7
) (
  input  logic [BUS_W-1:0] bus_data_i,
  input  logic             bus_sel_i,
  output logic             won_o
);
  logic [BUS_W-1:0] above;

  for (genvar b = 0; b < BUS_W; b++) begin : g_above
    assign above[b] = (b > OWN_ID);
  end

  assign won_o = ~|(bus_data_i & above) & ~bus_sel_i;
endmodule

// File: rtl/scsi_arbsel_seq.sv
module scsi_arbsel_seq
  import scsi_arbsel_pkg::*;
#(
  parameter int BUS_W        = 8,
  parameter int OWN_ID       = 7,
  parameter int BUS_FREE_CYC = 8,
  parameter int SETTLE_CYC   = 4,
  parameter int ARB_CYC      = 24,
  parameter int CLEAR_CYC    = 8,
  parameter int TMO_W        = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     arb_start_i,
  input  logic                     sel_start_i,
  input  logic                     atn_req_i,
  input  logic [$clog2(BUS_W)-1:0] dest_id_i,
  input  logic [TMO_W-1:0]         sel_tmo_i,
  input  logic                     bus_bsy_i,
  input  logic                     bus_sel_i,
  input  logic [BUS_W-1:0]         bus_data_i,
  output logic                     bsy_o,
  output logic                     sel_o,
  output logic                     atn_o,
  output logic [BUS_W-1:0]         data_o,
  output logic                     done_o,
  output logic                     arb_lost_o,
  output logic                     sel_tmo_o
);
  localparam int ID_W  = $clog2(BUS_W);
  localparam int DLY_W = $clog2(BUS_FREE_CYC + SETTLE_CYC + ARB_CYC + CLEAR_CYC + 1);
  localparam int CNT_W = (TMO_W > DLY_W) ? TMO_W : DLY_W;
  localparam logic [BUS_W-1:0] OWN_BIT = BUS_W'(1) << OWN_ID;
  localparam logic [CNT_W-1:0] LD_FREE   = CNT_W'(BUS_FREE_CYC + SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_RETRY  = CNT_W'(BUS_FREE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_CLEAR  = CNT_W'(CLEAR_CYC - 1);
  localparam logic [CNT_W-1:0] LD_ARB    = CNT_W'(ARB_CYC - 1);

  seq_state_e       state_q, state_d;
  logic             bsy_q, bsy_d, sel_q, sel_d, atn_q, atn_d;
  logic [BUS_W-1:0] data_q, data_d;
  logic             done_q, done_d, lost_q, lost_d, tmo_q, tmo_d;
  logic [ID_W-1:0]  dst_q, dst_d;
  logic             atn_req_q, atn_req_d;
  logic [TMO_W-1:0] tmo_val_q, tmo_val_d;
  logic             ld;
  logic [CNT_W-1:0] ld_val;
  logic             tmr_zero, won, bus_idle;

  arbsel_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ld),
    .load_val_i (ld_val),
    .zero_o     (tmr_zero)
  );

  arbsel_judge #(.BUS_W(BUS_W), .OWN_ID(OWN_ID)) i_judge (
    .bus_data_i (bus_data_i),
    .bus_sel_i  (bus_sel_i),
    .won_o      (won)
  );

  assign bus_idle = ~bus_bsy_i & ~bus_sel_i;

  always_comb begin
    state_d   = state_q;
    bsy_d     = bsy_q;
    sel_d     = sel_q;
    atn_d     = atn_q;
    data_d    = data_q;
    dst_d     = dst_q;
    atn_req_d = atn_req_q;
    tmo_val_d = tmo_val_q;
    done_d    = 1'b0;
    lost_d    = 1'b0;
    tmo_d     = 1'b0;
    ld        = 1'b0;
    ld_val    = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (arb_start_i) begin
          state_d = ST_BUS_FREE;
          ld      = 1'b1;
          bsy_d   = 1'b0;
          sel_d   = 1'b0;
          atn_d   = 1'b0;
          data_d  = '0;
        end else if (sel_start_i) begin
          state_d   = ST_SEL_BEGIN;
          ld        = 1'b1;
          dst_d     = dest_id_i;
          atn_req_d = atn_req_i;
          tmo_val_d = sel_tmo_i;
        end
      end
      ST_BUS_FREE: if (tmr_zero) begin
        ld = 1'b1;
        if (bus_idle) begin
          state_d = ST_ARB_BEGIN;
          ld_val  = LD_FREE;
        end else begin
          ld_val  = LD_RETRY;
        end
      end
      ST_ARB_BEGIN: if (tmr_zero) begin
        ld = 1'b1;
        if (!bus_idle) begin
          // bus taken during settle: back off and wait for a clear bus
          state_d = ST_BUS_FREE;
          ld_val  = LD_CLEAR;
          bsy_d   = 1'b0;
          data_d  = '0;
        end else begin
          state_d = ST_ARB_END;
          ld_val  = LD_ARB;
          bsy_d   = 1'b1;
          data_d  = OWN_BIT;
        end
      end
      ST_ARB_END: if (tmr_zero) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
        if (won) begin
          sel_d = 1'b1;
        end else begin
          lost_d = 1'b1;
          bsy_d  = 1'b0;
          sel_d  = 1'b0;
          atn_d  = 1'b0;
          data_d = '0;
        end
      end
      ST_SEL_BEGIN: if (tmr_zero) begin
        state_d = ST_SEL_END;
        ld      = 1'b1;
        ld_val  = (tmo_val_q == '0) ? '0 : CNT_W'(tmo_val_q - 1'b1);
        sel_d   = 1'b1;
        bsy_d   = 1'b0;
        atn_d   = atn_req_q;
        data_d  = OWN_BIT | (BUS_W'(1) << dst_q);
      end
      ST_SEL_END: if (tmr_zero) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
        sel_d   = 1'b0;
        data_d  = '0;
        if (!bus_bsy_i) begin
          tmo_d = 1'b1;
          atn_d = 1'b0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bsy_q     <= 1'b0;
      sel_q     <= 1'b0;
      atn_q     <= 1'b0;
      data_q    <= '0;
      done_q    <= 1'b0;
      lost_q    <= 1'b0;
      tmo_q     <= 1'b0;
      dst_q     <= '0;
      atn_req_q <= 1'b0;
      tmo_val_q <= '0;
    end else begin
      state_q   <= state_d;
      bsy_q     <= bsy_d;
      sel_q     <= sel_d;
      atn_q     <= atn_d;
      data_q    <= data_d;
      done_q    <= done_d;
      lost_q    <= lost_d;
      tmo_q     <= tmo_d;
      dst_q     <= dst_d;
      atn_req_q <= atn_req_d;
      tmo_val_q <= tmo_val_d;
    end
  end

  assign bsy_o      = bsy_q;
  assign sel_o      = sel_q;
  assign atn_o      = atn_q;
  assign data_o     = data_q;
  assign done_o     = done_q;
  assign arb_lost_o = lost_q;
  assign sel_tmo_o  = tmo_q;
endmodule

// File: rtl/scsi_arbsel_chk.sv
module scsi_arbsel_chk #(
  parameter int BUS_W  = 8,
  parameter int OWN_ID = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bsy_o,
  input logic             sel_o,
  input logic             atn_o,
  input logic [BUS_W-1:0] data_o,
  input logic             done_o,
  input logic             arb_lost_o,
  input logic             sel_tmo_o
);
  localparam logic [BUS_W-1:0] OWN_BIT = BUS_W'(1) << OWN_ID;

  // R2
  bsy_own_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bsy_o) |-> (data_o == OWN_BIT) && !sel_o);

  // R5
  win_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sel_o) && bsy_o) |-> done_o && !arb_lost_o && (data_o == OWN_BIT));

  // R6
  lost_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_lost_o |-> done_o && !bsy_o && !sel_o && !atn_o && (data_o == '0));

  // R8
  sel_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(bsy_o) && sel_o) |-> ((data_o & OWN_BIT) != '0) && ($countones(data_o) <= 2));

  // R9
  tmo_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_tmo_o |-> done_o && !bsy_o && !sel_o && !atn_o && (data_o == '0));

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(arb_lost_o && sel_tmo_o));
endmodule

bind scsi_arbsel_seq scsi_arbsel_chk #(.BUS_W(BUS_W), .OWN_ID(OWN_ID)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bsy_o      (bsy_o),
  .sel_o      (sel_o),
  .atn_o      (atn_o),
  .data_o     (data_o),
  .done_o     (done_o),
  .arb_lost_o (arb_lost_o),
  .sel_tmo_o  (sel_tmo_o)
);

// File: tb/test_scsi_arbsel_seq.sv
module test_scsi_arbsel_seq;
  localparam int OWN = 5;
  localparam int ARB_LAT = 38;

  typedef struct {
    logic       lost, tmo, sel, bsy, atn;
    logic [7:0] data;
    int         lat;
    int         t0;
    string      req;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic arb_start = 0, sel_start = 0, atn_req = 0;
  logic [2:0] dest = '0;
  logic [15:0] tmo = '0;
  logic bus_bsy = 0, bus_sel = 0;
  logic [7:0] oth_data = '0;
  logic [7:0] bus_data;
  logic bsy_o, sel_o, atn_o, done_o, arb_lost_o, sel_tmo_o;
  logic [7:0] data_o;
  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;
  exp_t exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign bus_data = data_o | oth_data;

  scsi_arbsel_seq #(.OWN_ID(OWN)) i_scsi_arbsel_seq (
    .clk_i(clk), .rst_ni(rst_n), .arb_start_i(arb_start), .sel_start_i(sel_start),
    .atn_req_i(atn_req), .dest_id_i(dest), .sel_tmo_i(tmo), .bus_bsy_i(bus_bsy),
    .bus_sel_i(bus_sel), .bus_data_i(bus_data), .bsy_o(bsy_o), .sel_o(sel_o),
    .atn_o(atn_o), .data_o(data_o), .done_o(done_o), .arb_lost_o(arb_lost_o),
    .sel_tmo_o(sel_tmo_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic start(input bit arb, input bit sel, input logic [2:0] d, input bit atn,
                       input int t, input exp_t e);
    arb_start = arb; sel_start = sel; dest = d; atn_req = atn; tmo = 16'(t);
    e.t0 = cyc;
    if (e.req != "") exp_q.push_back(e);
    @(negedge clk);
    arb_start = 0; sel_start = 0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic exp_t mk(input logic lost, tmo_f, sel, bsy, atn, input logic [7:0] d,
                              input int lat, input string req);
    exp_t e;
    e.lost = lost; e.tmo = tmo_f; e.sel = sel; e.bsy = bsy; e.atn = atn;
    e.data = d; e.lat = lat; e.t0 = 0; e.req = req;
    return e;
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done_o) begin
        if (exp_q.size() == 0) begin
          chk(0, "R10 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk({arb_lost_o, sel_tmo_o, sel_o, bsy_o, atn_o} == {e.lost, e.tmo, e.sel, e.bsy, e.atn},
              {e.req, " flags"}, {arb_lost_o, sel_tmo_o, sel_o, bsy_o, atn_o},
              {e.lost, e.tmo, e.sel, e.bsy, e.atn});
          chk(data_o == e.data, {e.req, " data"}, data_o, e.data);
          if (e.lat != 0) chk(cyc - e.t0 == e.lat, {e.req, " latency"}, cyc - e.t0, e.lat);
        end
      end else if (arb_lost_o || sel_tmo_o) begin
        chk(0, "R11 flag without done", {arb_lost_o, sel_tmo_o}, 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({bsy_o, sel_o, atn_o, done_o, arb_lost_o, sel_tmo_o} == 6'b0 && data_o == 0,
        "R1 reset", {bsy_o, sel_o, atn_o, done_o, arb_lost_o, sel_tmo_o, data_o}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 R5 R10: free bus, both starts together -> arbitration, win
    start(1, 1, 3'd2, 1, 40, mk(0, 0, 1, 1, 0, 8'h20, ARB_LAT, "R2 R5 R10 win"));
    repeat (15) @(negedge clk);
    chk(bsy_o && data_o == 8'h20 && !sel_o, "R2 arbitrating", {bsy_o, sel_o, data_o}, 10'h220);
    wait_idle();

    // R8 R10: select dest 2 with ATN, target answers; late starts ignored
    start(0, 1, 3'd2, 1, 40, mk(0, 0, 0, 0, 1, 8'h00, 42, "R8 select ok"));
    repeat (4) @(negedge clk);
    start(1, 1, 3'd7, 0, 5, mk(0, 0, 0, 0, 0, 0, 0, ""));
    repeat (4) @(negedge clk);
    chk(data_o == 8'h24 && sel_o && !bsy_o && atn_o, "R8 R10 select drive",
        {sel_o, bsy_o, atn_o, data_o}, 11'h524);
    repeat (10) @(negedge clk);
    bus_bsy = 1;
    wait_idle();
    bus_bsy = 0;
    repeat (2) @(negedge clk);

    // R6: higher ID present
    oth_data = 8'h80;
    start(1, 0, 0, 0, 0, mk(1, 0, 0, 0, 0, 8'h00, ARB_LAT, "R6 higher id"));
    wait_idle();

    // R5: only lower ID present -> win
    oth_data = 8'h01;
    start(1, 0, 0, 0, 0, mk(0, 0, 1, 1, 0, 8'h20, ARB_LAT, "R5 lower id"));
    wait_idle();
    oth_data = 8'h00;

    // R7: SEL asserted by another device during arbitration
    start(1, 0, 0, 0, 0, mk(1, 0, 0, 0, 0, 8'h00, ARB_LAT, "R7 foreign sel"));
    repeat (19) @(negedge clk);
    bus_sel = 1;
    wait_idle();
    bus_sel = 0;

    // R9: no response, ATN off
    start(0, 1, 3'd6, 0, 30, mk(0, 1, 0, 0, 0, 8'h00, 32, "R9 timeout"));
    repeat (10) @(negedge clk);
    chk(data_o == 8'h60 && !atn_o, "R8 no atn", {atn_o, data_o}, 9'h060);
    wait_idle();

    // R3: bus busy, block polls and stays off the bus
    bus_bsy = 1;
    start(1, 0, 0, 0, 0, mk(0, 0, 1, 1, 0, 8'h20, 0, "R3 busy then win"));
    repeat (30) @(negedge clk);
    chk(!bsy_o && !sel_o && data_o == 0, "R3 off bus", {bsy_o, sel_o, data_o}, 0);
    repeat (20) @(negedge clk);
    bus_bsy = 0;
    wait_idle();

    // R4: bus taken during settle -> back off CLEAR_CYC, retry
    start(1, 0, 0, 0, 0, mk(0, 0, 1, 1, 0, 8'h20, 58, "R4 clear retry"));
    repeat (5) @(negedge clk);
    bus_bsy = 1;
    repeat (9) @(negedge clk);
    chk(!bsy_o && data_o == 0, "R4 off bus", {bsy_o, data_o}, 0);
    bus_bsy = 0;
    wait_idle();

    chk(exp_q.size() == 0, "R11 all done seen", exp_q.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule